// File: doc/BRIEF.md
# Timing Signal Routing Matrix

This block is a configurable crossbar between the outside world and a set of internal timing signals. On the outside are ten programmable function pins and seven lines of a trigger bus that several boards share. On the inside are eight timing signals. Each internal signal takes its source from one of three places, chosen by a register field: any pin, any bus line, or nothing. If nothing is chosen, the signal is held low. Any number of internal signals may choose the same pin or line at the same time.

Each pin and each bus line also has its own output enable. A pin that is enabled drives one fixed internal signal, which is the pin index modulo eight. For example, pin 5 carries signal 5, the update strobe. A bus line that is enabled drives whichever internal signal its own drive-select field names.

Internal signal 0 is the timebase. Putting it on the bus means choosing drive-select 0 for a line. Taking the timebase from another board means choosing a bus line as the source of signal 0.

External inputs are synchronized to the block clock before they are routed. The outputs are presented as a value plus an enable, for tri-state pads outside the block.

Top module: `trm_route_matrix`

## Requirements
- R1: After synchronous reset, every pin and line enable is 0 and every pin and line output is 0. Every source field resets to code 31, so every routed signal reads 0.
- R2: Writing address s (0..7) sets bits [4:0] of the data as the source code of signal s. Codes 0..9 select pin n. A change on a selected pin input appears on rt_sig_o after the second rising clock edge, and not after the first.
- R3: Source codes 10..16 select bus line (code-10).
- R4: Source code 31, and any unused code from 17 to 30, forces the routed signal to 0 from the cycle after the write, whatever the inputs are.
- R5: Several internal signals may select the same pin at once, and each of them follows that pin.
- R6: Address 8 bits [9:0] are the pin output enables. An enabled pin p gives pin_oe_o[p]=1 and pin_o[p]=int_sig_i[p mod 8]. A disabled pin gives 0 on both.
- R7: Address 9 bits [6:0] are the line output enables. Address 10+l bits [2:0] are the drive select of line l. An enabled line gives line_o[l]=int_sig_i[select]. A disabled line gives 0 on both outputs.
- R8: A pin or line whose output enable is set routes its own driven value, not its external input, to any internal signal that selects it.
- R9: Internal signal 0 is the timebase. It can be driven onto a bus line with drive select 0, and it can be taken from a bus line by giving signal 0 a source code from 10 to 16.
- R10: Writes to addresses 17..31 change no configuration and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Register write data |
| pin_i | input | 10 | Function pin inputs |
| pin_o | output | 10 | Function pin output values |
| pin_oe_o | output | 10 | Function pin output enables |
| line_i | input | 7 | Trigger bus line inputs |
| line_o | output | 7 | Trigger bus line output values |
| line_oe_o | output | 7 | Trigger bus line output enables |
| int_sig_i | input | 8 | Internal timing signals available for driving out |
| rt_sig_o | output | 8 | Routed internal timing signals |

## Verification
The bench builds the block with its default sizes: ten pins, seven bus lines and eight internal signals. At these sizes every source code class can be reached, including the last pin (9), the last line (16) and the unused codes above 16. Pin indices 8 and 9 wrap onto signals 0 and 1 under the modulo mapping, so the bench can exercise that wrap. One line drive select per index is enough to exercise loopback and timebase sharing.

// File: rtl/trm_pkg.sv
package trm_pkg;
    localparam int NPIN     = 10;
    localparam int NLINE    = 7;
    localparam int NSIG     = 8;
    localparam int SEL_W    = 5;
    localparam int DSEL_W   = $clog2(NSIG);
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int CODE_LINE0 = NPIN;
    localparam int A_PIN_OE   = NSIG;
    localparam int A_LINE_OE  = NSIG + 1;
    localparam int A_DSEL0    = NSIG + 2;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [DSEL_W-1:0] dsel_t;

    localparam sel_t CODE_NONE = '1;

    typedef struct packed {
        sel_t  [NSIG-1:0]  src;
        logic  [NPIN-1:0]  pin_oe;
        logic  [NLINE-1:0] line_oe;
        dsel_t [NLINE-1:0] dsel;
    } cfg_t;

    typedef enum logic [1:0] {
        SRC_PIN  = 2'd0,
        SRC_LINE = 2'd1,
        SRC_NONE = 2'd2
    } src_kind_e;

    function automatic src_kind_e decode_kind(sel_t code);
        if (int'(code) < NPIN)
            return SRC_PIN;
        else if (int'(code) < NPIN + NLINE)
            return SRC_LINE;
        else
            return SRC_NONE;
    endfunction

    function automatic int pin_sig(int p);
        return p % NSIG;
    endfunction
endpackage

// File: rtl/trm_regs.sv
module trm_regs
    import trm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSIG; s++) cfg.src[s] <= CODE_NONE;
            cfg.pin_oe  <= '0;
            cfg.line_oe <= '0;
            for (int l = 0; l < NLINE; l++) cfg.dsel[l] <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < NSIG; s++)
                if (wr_addr == ADDR_W'(s)) cfg.src[s] <= wr_data[SEL_W-1:0];
            if (wr_addr == ADDR_W'(A_PIN_OE))
                cfg.pin_oe <= wr_data[NPIN-1:0];
            if (wr_addr == ADDR_W'(A_LINE_OE))
                cfg.line_oe <= wr_data[NLINE-1:0];
            for (int l = 0; l < NLINE; l++)
                if (wr_addr == ADDR_W'(A_DSEL0 + l)) cfg.dsel[l] <= wr_data[DSEL_W-1:0];
        end
    end
endmodule

// File: rtl/trm_drive.sv
module trm_drive
    import trm_pkg::*;
(
    input  cfg_t             cfg,
    input  logic [NSIG-1:0]  int_sig,
    input  logic [NPIN-1:0]  pin_i,
    input  logic [NLINE-1:0] line_i,
    output logic [NPIN-1:0]  pin_o,
    output logic [NPIN-1:0]  pin_oe,
    output logic [NLINE-1:0] line_o,
    output logic [NLINE-1:0] line_oe,
    output logic [NPIN-1:0]  pin_eff,
    output logic [NLINE-1:0] line_eff
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign pin_oe[p]  = cfg.pin_oe[p];
        assign pin_o[p]   = cfg.pin_oe[p] & int_sig[pin_sig(p)];
        // loopback: an enabled pin routes what it drives
        assign pin_eff[p] = cfg.pin_oe[p] ? pin_o[p] : pin_i[p];
    end

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        assign line_oe[l]  = cfg.line_oe[l];
        assign line_o[l]   = cfg.line_oe[l] & int_sig[cfg.dsel[l]];
        assign line_eff[l] = cfg.line_oe[l] ? line_o[l] : line_i[l];
    end
endmodule

// File: rtl/trm_sync.sv
module trm_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/trm_src_mux.sv
module trm_src_mux
    import trm_pkg::*;
(
    input  sel_t             code,
    input  logic [NPIN-1:0]  pins,
    input  logic [NLINE-1:0] lines,
    output logic             out
);
    always_comb begin
        out = 1'b0;
        unique case (decode_kind(code))
            SRC_PIN: begin
                for (int p = 0; p < NPIN; p++)
                    if (code == SEL_W'(p)) out = pins[p];
            end
            SRC_LINE: begin
                for (int l = 0; l < NLINE; l++)
                    if (code == SEL_W'(CODE_LINE0 + l)) out = lines[l];
            end
            default: out = 1'b0;
        endcase
    end
endmodule

// File: rtl/trm_route_matrix.sv
module trm_route_matrix
    import trm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NPIN-1:0]   pin_i,
    output logic [NPIN-1:0]   pin_o,
    output logic [NPIN-1:0]   pin_oe_o,
    input  logic [NLINE-1:0]  line_i,
    output logic [NLINE-1:0]  line_o,
    output logic [NLINE-1:0]  line_oe_o,
    input  logic [NSIG-1:0]   int_sig_i,
    output logic [NSIG-1:0]   rt_sig_o
);
    localparam int SYNC_W = NPIN + NLINE;

    cfg_t             cfg;
    logic [NPIN-1:0]  pin_eff;
    logic [NLINE-1:0] line_eff;
    logic [SYNC_W-1:0] sync_q;

    trm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    trm_drive u_drive (
        .cfg      (cfg),
        .int_sig  (int_sig_i),
        .pin_i    (pin_i),
        .line_i   (line_i),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe_o),
        .line_o   (line_o),
        .line_oe  (line_oe_o),
        .pin_eff  (pin_eff),
        .line_eff (line_eff)
    );

    trm_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({line_eff, pin_eff}),
        .q   (sync_q)
    );

    for (genvar s = 0; s < NSIG; s++) begin : g_sig
        trm_src_mux u_mux (
            .code  (cfg.src[s]),
            .pins  (sync_q[NPIN-1:0]),
            .lines (sync_q[SYNC_W-1:NPIN]),
            .out   (rt_sig_o[s])
        );
    end
endmodule

// File: rtl/trm_route_chk.sv
module trm_route_chk
    import trm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [NPIN-1:0]   pin_i,
    input logic [NPIN-1:0]   pin_o,
    input logic [NPIN-1:0]   pin_oe_o,
    input logic [NLINE-1:0]  line_i,
    input logic [NLINE-1:0]  line_o,
    input logic [NLINE-1:0]  line_oe_o,
    input logic [NSIG-1:0]   int_sig_i,
    input logic [NSIG-1:0]   rt_sig_o
);
    // R1
    reset_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe_o == '0 && line_oe_o == '0 && rt_sig_o == '0));

    // R6
    pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_o & ~pin_oe_o) == '0);

    // R7
    line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (line_o & ~line_oe_o) == '0);

    for (genvar p = 0; p < NPIN; p++) begin : g_pchk
        // R6
        pin_drive_chk: assert property (@(posedge clk) disable iff (rst)
            pin_oe_o[p] |-> (pin_o[p] == int_sig_i[pin_sig(p)]));
    end

    for (genvar s = 0; s < NSIG; s++) begin : g_schk
        // R4
        no_source_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(s) && int'(wr_data[SEL_W-1:0]) >= NPIN + NLINE)
            |=> (rt_sig_o[s] == 1'b0));
    end
endmodule

bind trm_route_matrix trm_route_chk u_chk (.*);

// File: tb/trm_route_matrix_test.sv
module trm_route_matrix_test;
    import trm_pkg::*;

    typedef struct packed {
        logic        we;
        logic [4:0]  addr;
        logic [15:0] data;
        logic [9:0]  pin;
        logic [6:0]  line;
        logic [7:0]  isig;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    // requirement tags used below: R2 R3 R4 R5 R6 R7 R8 R9 R10
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd0,  16'd3,     10'h008, 7'h00, 8'h00, 4'd2},
        '{1'b1, 5'd1,  16'd3,     10'h008, 7'h00, 8'h00, 4'd5},
        '{1'b1, 5'd2,  16'd12,    10'h000, 7'h04, 8'h00, 4'd3},
        '{1'b1, 5'd3,  16'd16,    10'h000, 7'h40, 8'h00, 4'd3},
        '{1'b1, 5'd1,  16'd25,    10'h008, 7'h00, 8'h00, 4'd4},
        '{1'b1, 5'd6,  16'd31,    10'h3FF, 7'h7F, 8'h00, 4'd4},
        '{1'b1, 5'd8,  16'h0020,  10'h000, 7'h00, 8'h20, 4'd6},
        '{1'b1, 5'd8,  16'h03FF,  10'h000, 7'h00, 8'hA5, 4'd6},
        '{1'b1, 5'd4,  16'd5,     10'h000, 7'h00, 8'h20, 4'd8},
        '{1'b1, 5'd9,  16'h0001,  10'h000, 7'h00, 8'h20, 4'd7},
        '{1'b1, 5'd10, 16'd5,     10'h000, 7'h00, 8'h20, 4'd7},
        '{1'b1, 5'd5,  16'd10,    10'h000, 7'h00, 8'h20, 4'd8},
        '{1'b1, 5'd11, 16'd0,     10'h000, 7'h00, 8'h01, 4'd9},
        '{1'b1, 5'd9,  16'h0003,  10'h000, 7'h00, 8'h01, 4'd9},
        '{1'b1, 5'd0,  16'd11,    10'h000, 7'h00, 8'h01, 4'd9},
        '{1'b1, 5'd9,  16'h0001,  10'h000, 7'h02, 8'h00, 4'd9},
        '{1'b1, 5'd20, 16'hFFFF,  10'h000, 7'h02, 8'h00, 4'd10},
        '{1'b1, 5'd8,  16'h0000,  10'h2AA, 7'h55, 8'h00, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [9:0]  pin_i = '0;
    logic [9:0]  pin_o, pin_oe_o;
    logic [6:0]  line_i = '0;
    logic [6:0]  line_o, line_oe_o;
    logic [7:0]  int_sig_i = '0;
    logic [7:0]  rt_sig_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [4:0] m_src [8];
    logic [9:0] m_poe;
    logic [6:0] m_loe;
    logic [2:0] m_dsel [7];

    always #4 clk = ~clk;

    trm_route_matrix uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
        .line_i(line_i), .line_o(line_o), .line_oe_o(line_oe_o),
        .int_sig_i(int_sig_i), .rt_sig_o(rt_sig_o)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 8; s++) m_src[s] = 5'd31;
        for (int l = 0; l < 7; l++) m_dsel[l] = 3'd0;
        m_poe = '0;
        m_loe = '0;
    endtask

    task automatic model_write(input logic [4:0] a, input logic [15:0] d);
        if (a < 5'd8) m_src[a[2:0]] = d[4:0];
        else if (a == 5'd8) m_poe = d[9:0];
        else if (a == 5'd9) m_loe = d[6:0];
        else if (a <= 5'd16) m_dsel[a - 5'd10] = d[2:0];
    endtask

    function automatic logic [9:0] exp_pin_o();
        logic [9:0] r;
        for (int p = 0; p < 10; p++) r[p] = m_poe[p] & int_sig_i[p % 8];
        return r;
    endfunction

    function automatic logic [6:0] exp_line_o();
        logic [6:0] r;
        for (int l = 0; l < 7; l++) r[l] = m_loe[l] & int_sig_i[m_dsel[l]];
        return r;
    endfunction

    function automatic logic [7:0] exp_rt();
        logic [7:0] r;
        logic [9:0] pe;
        logic [6:0] le;
        pe = (m_poe & exp_pin_o()) | (~m_poe & pin_i);
        le = (m_loe & exp_line_o()) | (~m_loe & line_i);
        for (int s = 0; s < 8; s++) begin
            if (m_src[s] < 5'd10) r[s] = pe[m_src[s]];
            else if (m_src[s] <= 5'd16) r[s] = le[m_src[s] - 5'd10];
            else r[s] = 1'b0;
        end
        return r;
    endfunction

    task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_all(input int req);
        check(req, {24'd0, rt_sig_o}, {24'd0, exp_rt()});
        check(req, {12'd0, pin_oe_o, pin_o}, {12'd0, m_poe, exp_pin_o()});
        check(req, {18'd0, line_oe_o, line_o}, {18'd0, m_loe, exp_line_o()});
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        pin_i = '1; line_i = '1; int_sig_i = '1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: everything quiet after reset, inputs all high
        check(1, {22'd0, pin_oe_o, line_oe_o}, 32'd0);
        check(1, {22'd0, pin_o, line_o}, 32'd0);
        check(1, {24'd0, rt_sig_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pin_i = VECS[i].pin; line_i = VECS[i].line; int_sig_i = VECS[i].isig;
            if (VECS[i].we) reg_write(VECS[i].addr, VECS[i].data);
            repeat (3) @(negedge clk);
            check_all(int'(VECS[i].req));
        end

        // R2: two-edge input latency, pin 3 selected by signal 0
        reg_write(5'd0, 16'd3);
        pin_i = '0;
        repeat (3) @(negedge clk);
        check(2, {31'd0, rt_sig_o[0]}, 32'd0);
        pin_i[3] = 1'b1;
        @(negedge clk);
        check(2, {31'd0, rt_sig_o[0]}, 32'd0);
        @(negedge clk);
        check(2, {31'd0, rt_sig_o[0]}, 32'd1);

        // R4: no-source write takes effect on the next cycle
        reg_write(5'd0, 16'd31);
        check(4, {31'd0, rt_sig_o[0]}, 32'd0);

        // R10: unused address leaves pin enables untouched
        reg_write(5'd8, 16'h0200);
        int_sig_i = 8'h02;
        reg_write(5'd31, 16'h0000);
        @(negedge clk);
        check(10, {22'd0, pin_oe_o, pin_o}, {22'd0, 10'h200, 10'h200});

        // R1: reset in mid-run clears configuration
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        model_reset();
        pin_i = '1; line_i = '1;
        repeat (3) @(negedge clk);
        check(1, {22'd0, pin_oe_o, line_oe_o}, 32'd0);
        check(1, {24'd0, rt_sig_o}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule